// File: doc/BRIEF.md
# Coprocessor Select and Status Interface

This block sits on the CPU side of up to seven asynchronous coprocessors. It moves data between the general registers and coprocessor registers. It holds one shared status register at coprocessor register index 0. That register records which coprocessors are enabled and which single coprocessor is active. Index 0 can always be reached. Indices 1 to 15 go to the active coprocessor, and only when that coprocessor is both present and enabled; otherwise the request raises a coprocessor trap.

The CPU presents one request per cycle: a get or a set, a 4-bit register index and write data. A set to an active coprocessor produces a one-cycle start strobe to that unit, along with the index and the data. A get from an active coprocessor returns that unit's data and N/Z/V/C flags once its ready line is high. Until then the block raises a stall, and the CPU keeps presenting the same request. A get of the status register returns the register and derives the flags from its value. All results are combinational on the request. Only the status register is state.

Top module: `cop_sel_ctrl`

## Requirements
- R1: After reset the status register reads as zero, and with no request pending the trap, stall, flag-write, start and take outputs are all 0 and rd_data is zero.
- R2: A set to index 0 stores bits 10:8 of the write data as the active-select field (0 = none, k = coprocessor k). It stores bit k (k = 1..7) as the enable of coprocessor k, but only if cp_present[k-1] is high. A later get of index 0 returns exactly those fields, and every other bit reads zero.
- R3: A get of index 0 asserts flags_we and drives flags_out = {N,Z,V,C} (bit 3 down to bit 0), with Z = 1 when the value read is zero and N, V, C = 0.
- R4: Index 0 never traps and never stalls, whatever the select field and enable bits hold.
- R5: Enabling a coprocessor does not select it: with the select field at 0, a get or set to indices 1 to 15 traps even when enables are set.
- R6: A get or set to indices 1 to 15 traps when the selected coprocessor is absent or not enabled. A trapping request gives no start, no take, no stall and no flag write.
- R7: A set to indices 1 to 15 with a valid selection asserts cp_start[k-1] only, for selected coprocessor k, in the same cycle. cp_idx and cp_wdata carry the request's index and data, and flags_we stays 0.
- R8: A get with a valid selection stalls, with no flag write and no take, while the selected unit's ready is low. Once that ready is high, in the same cycle, the block returns that unit's slice of cp_rdata and cp_flags (unit k at slice k-1), asserts flags_we and pulses cp_take[k-1].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_get | input | 1 | 1 = get (read), 0 = set (write) |
| req_idx | input | 4 | Coprocessor register index; 0 = status register |
| req_wdata | input | DW | Data for a set |
| cp_present | input | NCP | Bit k-1 high when coprocessor k is fitted |
| cp_ready | input | NCP | Bit k-1 high when coprocessor k has get data valid |
| cp_rdata | input | NCP*DW | Get data, coprocessor k in slice k-1 |
| cp_flags | input | NCP*4 | N/Z/V/C from each coprocessor, coprocessor k in slice k-1 |
| rd_data | output | DW | Data returned by a completing get, else zero |
| flags_out | output | 4 | {N,Z,V,C} for a completing get, else zero |
| flags_we | output | 1 | CPU should load flags_out into its condition codes |
| stall | output | 1 | Hold the CPU; the get waits on the coprocessor |
| trap | output | 1 | Coprocessor trap for this request |
| cp_start | output | NCP | One-cycle set strobe to the active coprocessor |
| cp_take | output | NCP | One-cycle strobe when a get is consumed |
| cp_idx | output | 4 | Register index toward the coprocessors |
| cp_wdata | output | DW | Write data toward the coprocessors |

## Verification
The assertions take for granted that the CPU keeps the same request steady while stall is high. They also assume that cp_present changes only while no request is outstanding, so the mask applied to the enables at a status write refers to a stable set of units. The stimulus meets both conditions. It changes the request only at a falling edge after the previous one has completed, repeats a stalled get unchanged until ready is raised, and holds cp_present constant for the whole run.

// File: rtl/cop_sel_ctrl.sv
module cop_sel_ctrl #(
  parameter int NCP = 7,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_get,
  input  logic [3:0]        req_idx,
  input  logic [DW-1:0]     req_wdata,
  input  logic [NCP-1:0]    cp_present,
  input  logic [NCP-1:0]    cp_ready,
  input  logic [NCP*DW-1:0] cp_rdata,
  input  logic [NCP*4-1:0]  cp_flags,
  output logic [DW-1:0]     rd_data,
  output logic [3:0]        flags_out,
  output logic              flags_we,
  output logic              stall,
  output logic              trap,
  output logic [NCP-1:0]    cp_start,
  output logic [NCP-1:0]    cp_take,
  output logic [3:0]        cp_idx,
  output logic [DW-1:0]     cp_wdata
);

  localparam int SELW   = $clog2(NCP + 1);
  localparam int SEL_LO = 8;

  logic [NCP-1:0]  en_q;
  logic [SELW-1:0] sel_q;
  logic [NCP-1:0]  sel_oh;
  logic [DW-1:0]   stat_val;
  logic [DW-1:0]   cp_dat;
  logic [3:0]      cp_flg;

  wire stat_acc = (req_idx == 4'd0);
  wire stat_wr  = req_valid & ~req_get & stat_acc;
  wire stat_rd  = req_valid &  req_get & stat_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
    end else if (stat_wr) begin
      en_q  <= req_wdata[NCP:1] & cp_present;
      sel_q <= req_wdata[SEL_LO +: SELW];
    end
  end

  always_comb begin
    stat_val = '0;
    stat_val[NCP:1] = en_q;
    stat_val[SEL_LO +: SELW] = sel_q;
  end

  for (genvar k = 0; k < NCP; k++) begin : g_sel
    assign sel_oh[k] = (sel_q == SELW'(k + 1));
  end

  always_comb begin
    cp_dat = '0;
    cp_flg = '0;
    for (int k = 0; k < NCP; k++) begin
      if (sel_oh[k]) begin
        cp_dat = cp_rdata[k*DW +: DW];
        cp_flg = cp_flags[k*4 +: 4];
      end
    end
  end

  wire sel_ok   = |(sel_oh & en_q & cp_present);
  wire sel_rdy  = |(sel_oh & cp_ready);
  wire cp_acc   = req_valid & ~stat_acc;
  wire cp_go    = cp_acc & sel_ok;
  wire get_done = cp_go & req_get & sel_rdy;

  assign trap      = cp_acc & ~sel_ok;
  assign stall     = cp_go & req_get & ~sel_rdy;
  assign cp_start  = {NCP{cp_go & ~req_get}} & sel_oh;
  assign cp_take   = {NCP{get_done}} & sel_oh;
  assign cp_idx    = req_idx;
  assign cp_wdata  = req_wdata;
  assign flags_we  = stat_rd | get_done;
  assign rd_data   = stat_rd ? stat_val : (get_done ? cp_dat : '0);
  assign flags_out = stat_rd ? {1'b0, stat_val == '0, 2'b00} : (get_done ? cp_flg : 4'b0);

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cp_start)); // R7
  AST_TAKE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cp_take)); // R8
  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (cp_start == '0 && cp_take == '0 && !stall && !flags_we)); // R6
  AST_STAT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_idx == 4'd0) |-> (!trap && !stall)); // R4
  AST_EN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> ((en_q & ~$past(cp_present)) == '0)); // R2
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ($stable(en_q) && $stable(sel_q))); // R2
  AST_STAT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (flags_we && !flags_out[3] && flags_out[1:0] == 2'b00)); // R3
  AST_STALL_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!flags_we && cp_take == '0 && cp_start == '0)); // R8
  AST_STALL_HELD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (req_valid && req_get && $stable(req_idx))); // R8

endmodule

// File: tb/cop_sel_ctrl_tb_top.sv
module cop_sel_ctrl_tb_top;
  localparam int NCP = 7;
  localparam int DW  = 32;

  logic clk = 0;
  logic rst_n = 0;
  always #5 clk = ~clk;

  logic              req_valid = 0, req_get = 0;
  logic [3:0]        req_idx = 0;
  logic [DW-1:0]     req_wdata = 0;
  logic [NCP-1:0]    cp_present = 7'b0010110;
  logic [NCP-1:0]    cp_ready = 0;
  logic [NCP*DW-1:0] cp_rdata;
  logic [NCP*4-1:0]  cp_flags;
  logic [DW-1:0]     rd_data;
  logic [3:0]        flags_out, cp_idx;
  logic              flags_we, stall, trap;
  logic [NCP-1:0]    cp_start, cp_take;
  logic [DW-1:0]     cp_wdata;

  initial begin
    for (int k = 0; k < NCP; k++) begin
      cp_rdata[k*DW +: DW] = 32'hC0DE_0000 + 32'(k + 1) * 32'h111;
      cp_flags[k*4 +: 4]   = 4'(k + 9);
    end
  end

  cop_sel_ctrl #(.NCP(NCP), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_get(req_get),
    .req_idx(req_idx), .req_wdata(req_wdata), .cp_present(cp_present),
    .cp_ready(cp_ready), .cp_rdata(cp_rdata), .cp_flags(cp_flags),
    .rd_data(rd_data), .flags_out(flags_out), .flags_we(flags_we),
    .stall(stall), .trap(trap), .cp_start(cp_start), .cp_take(cp_take),
    .cp_idx(cp_idx), .cp_wdata(cp_wdata));

  typedef struct { string tag; logic [87:0] v; } exp_t;
  exp_t exp_q[$];
  event chk_ev;
  int checks = 0, failures = 0;
  bit finished = 0;

  logic [6:0] en_m = 0;
  logic [2:0] sel_m = 0;

  task automatic do_req(input string tag, input bit v, input bit g,
                        input logic [3:0] idx, input logic [31:0] wd,
                        input logic [6:0] rdy);
    logic [31:0] stat, rd;
    logic [3:0]  fl;
    logic        fwe, tr, st, ok;
    logic [6:0]  start, take, oh;
    exp_t e;
    @(negedge clk);
    req_valid = v; req_get = g; req_idx = idx; req_wdata = wd; cp_ready = rdy;
    stat = {21'b0, sel_m, en_m, 1'b0};
    oh = (sel_m == 0) ? 7'b0 : (7'b1 << (sel_m - 1));
    ok = (oh & en_m & cp_present) != 0;
    rd = 0; fl = 0; fwe = 0; tr = 0; st = 0; start = 0; take = 0;
    if (v && idx == 0 && g) begin
      rd = stat; fl = {1'b0, stat == 0, 2'b0}; fwe = 1;
    end else if (v && idx != 0) begin
      if (!ok) tr = 1;
      else if (!g) start = oh;
      else if ((oh & rdy) == 0) st = 1;
      else begin
        rd = cp_rdata[(sel_m-1)*DW +: DW]; fl = cp_flags[(sel_m-1)*4 +: 4];
        fwe = 1; take = oh;
      end
    end
    e.tag = tag;
    e.v = {rd, fl, fwe, tr, st, start, take, idx, wd};
    exp_q.push_back(e);
    -> chk_ev;
    if (v && !g && idx == 0) begin
      en_m = wd[7:1] & cp_present;
      sel_m = wd[10:8];
    end
  endtask

  initial begin
    exp_t e;
    logic [87:0] act;
    forever begin
      @(chk_ev);
      #1;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        act = {rd_data, flags_out, flags_we, trap, stall, cp_start, cp_take, cp_idx, cp_wdata};
        checks++;
        if (act !== e.v) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", e.tag, act, e.v);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    do_req("R1 idle after reset", 0, 0, 0, 0, 0);
    do_req("R1 R3 status zero after reset", 1, 1, 0, 0, 0);
    do_req("R5 no selection traps get", 1, 1, 3, 0, 7'h7F);
    do_req("R2 write all enables select 7", 1, 0, 0, 32'hFFFF_F7FF, 0);
    do_req("R2 R3 readback masked nonzero", 1, 1, 0, 0, 0);
    do_req("R6 select absent unit get", 1, 1, 4, 0, 7'h7F);
    do_req("R6 select absent unit set", 1, 0, 2, 32'h1234, 0);
    do_req("R4 status read with bad select", 1, 1, 0, 0, 0);
    do_req("R2 enable cp2 select none", 1, 0, 0, 32'h0000_0004, 0);
    do_req("R2 readback enable only", 1, 1, 0, 0, 0);
    do_req("R5 enabled but unselected set", 1, 0, 1, 32'h55, 0);
    do_req("R5 enabled but unselected get", 1, 1, 15, 0, 7'h7F);
    do_req("R2 select cp3 disabled", 1, 0, 0, 32'h0000_0304, 0);
    do_req("R6 present but disabled set", 1, 0, 5, 32'h77, 0);
    do_req("R2 try enable absent cp1", 1, 0, 0, 32'h0000_0102, 0);
    do_req("R2 absent enable reads zero", 1, 1, 0, 0, 0);
    do_req("R6 select absent cp1", 1, 1, 1, 0, 7'h7F);
    do_req("R2 select cp2 enabled", 1, 0, 0, 32'h0000_0204, 0);
    do_req("R7 set start cp2", 1, 0, 9, 32'hDEAD_BEEF, 0);
    do_req("R7 set index 15", 1, 0, 15, 32'h0000_0001, 7'h7F);
    do_req("R8 get stall 1", 1, 1, 9, 0, 7'b1111101);
    do_req("R8 get stall 2", 1, 1, 9, 0, 7'b1111101);
    do_req("R8 get complete", 1, 1, 9, 0, 7'b0000010);
    do_req("R8 get ready at once", 1, 1, 2, 0, 7'b0000010);
    do_req("R2 select cp5 enable cp5", 1, 0, 0, 32'h0000_0520, 0);
    do_req("R8 get from cp5", 1, 1, 6, 0, 7'b0010000);
    do_req("R7 set to cp5", 1, 0, 6, 32'hA5A5_0000, 0);
    do_req("R4 status write zero", 1, 0, 0, 32'h0, 0);
    do_req("R3 status zero sets Z", 1, 1, 0, 0, 0);
    do_req("R1 idle again", 0, 1, 3, 0, 7'h7F);
    @(negedge clk);
    req_valid = 0;
    #2;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule